// File: doc/BRIEF.md
# Overlapping Triple-Run Detector

This block watches a serial stream of single bits and flags every bit that ends a run of three equal values. Either polarity counts: three ones in a row and three zeros in a row both raise the flag. Runs may overlap, so a run of N equal bits flags each bit from the third one to the Nth.

Bits enter on `bit_in` only in cycles where `bit_vld` is high. Cycles without a valid bit are skipped as if they were absent from the stream. The flag is a Mealy output: it rises combinationally in the same cycle as the completing bit. Internally, a five-state machine in D flip-flops tracks two things: the polarity of the current run, and whether that run has reached a length of one or two (or more). Reset is synchronous and active high.

Top module: `triple_run_detector`

## Requirements
- R1: Reset returns the machine to its empty state. After reset, `hit` stays 0 until at least three valid bits have arrived, and no bit seen before reset counts toward a run.
- R2: `hit` is 1 in the cycle where a valid `bit_in`=1 follows two earlier valid bits that were both 1.
- R3: `hit` is 1 in the cycle where a valid `bit_in`=0 follows two earlier valid bits that were both 0.
- R4: Detections overlap. While a run continues past three bits, every further valid bit of the same value also gives `hit`=1.
- R5: A valid bit of the opposite value starts a new run of length one. It never gives `hit`, and a strictly alternating stream never gives `hit`.
- R6: In a cycle with `bit_vld`=0, `hit` is 0 and `bit_in` is ignored. The run state holds, so a run continues across gaps of invalid cycles.
- R7: `hit` is only ever 1 while `bit_vld` is 1. It appears in the same cycle as the completing bit, with no register delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| bit_vld | input | 1 | High when `bit_in` carries a stream bit this cycle |
| bit_in | input | 1 | Serial data bit |
| hit | output | 1 | High when the current valid bit ends a run of three or more equal bits |

## Verification
On every cycle, the embedded properties check four things:
- the state holds across invalid cycles;
- `hit` appears only with a valid bit;
- no flag is raised from the empty state;
- a continuing run keeps flagging, and a polarity flip out of a length-two run lands in the one-bit state of the new polarity.

Whether each flag is correct for an arbitrary history can only be shown by the bench's scenarios, which compare `hit` against a shift-register model. Those scenarios cover long constant runs, alternation, gaps inside runs, and a reset that interrupts a partial run.

// File: rtl/triple_run_detector.sv
module triple_run_detector (
  input  logic clk,
  input  logic rst,
  input  logic bit_vld,
  input  logic bit_in,
  output logic hit
);

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_ONE1 = 3'd1,
    S_TWO1 = 3'd2,
    S_ONE0 = 3'd3,
    S_TWO0 = 3'd4
  } run_state_t;

  run_state_t state, state_nx;

  logic run_is_one, run_is_zero, run_long;

  assign run_is_one  = (state == S_ONE1) || (state == S_TWO1);
  assign run_is_zero = (state == S_ONE0) || (state == S_TWO0);
  assign run_long    = (state == S_TWO1) || (state == S_TWO0);

  always_comb begin
    state_nx = state;
    if (bit_vld) begin
      if (bit_in) state_nx = run_is_one  ? S_TWO1 : S_ONE1;
      else        state_nx = run_is_zero ? S_TWO0 : S_ONE0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= S_IDLE;
    else     state <= state_nx;
  end

  assign hit = bit_vld && run_long && (bit_in == run_is_one);

  a_r6_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !bit_vld |=> $stable(state));

  a_r7_hit_needs_valid: assert property (@(posedge clk) disable iff (rst)
    hit |-> bit_vld);

  a_r1_no_hit_from_empty: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE) |-> !hit);

  a_r4_overlap_continues: assert property (@(posedge clk) disable iff (rst)
    hit ##1 (bit_vld && (bit_in == $past(bit_in))) |-> hit);

  a_r5_flip_from_ones: assert property (@(posedge clk) disable iff (rst)
    (bit_vld && !bit_in && state == S_TWO1) |=> state == S_ONE0);

  a_r5_flip_from_zeros: assert property (@(posedge clk) disable iff (rst)
    (bit_vld && bit_in && state == S_TWO0) |=> state == S_ONE1);

endmodule

// File: tb/triple_run_detector_tb.sv
`timescale 1ns/1ps
module triple_run_detector_tb;

  logic clk = 1'b0;
  logic rst, bit_vld, bit_in;
  logic hit;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [1:0] hist;
  int seen;

  always #2.5 clk = ~clk;

  triple_run_detector u_dut (
    .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_in(bit_in), .hit(hit)
  );

  localparam int NVEC = 26;
  // {bit_vld, bit_in, expected hit}
  localparam logic [2:0] VEC [NVEC] = '{
    3'b110, 3'b110, 3'b111, 3'b111, 3'b100, 3'b100, 3'b101, 3'b101,
    3'b110, 3'b100, 3'b110, 3'b100, 3'b110, 3'b110, 3'b000, 3'b111,
    3'b100, 3'b010, 3'b100, 3'b101, 3'b110, 3'b110, 3'b100, 3'b100,
    3'b110, 3'b110
  };

  task automatic check(input string tag, input logic got, input logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: hit=%b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic model(input logic v, input logic x);
    return v && (seen >= 2) && (hist[0] == x) && (hist[1] == x);
  endfunction

  task automatic model_step(input logic v, input logic x);
    if (v) begin
      hist = {hist[0], x};
      if (seen < 3) seen++;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; bit_vld = 1'b0; bit_in = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    hist = 2'b00; seen = 0;
  endtask

  task automatic drive(input logic v, input logic x, input string tag);
    @(negedge clk);
    bit_vld = v; bit_in = x;
    #1;
    check(tag, hit, model(v, x));
    model_step(v, x);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; bit_vld = 1'b0; bit_in = 1'b0;
    hist = 2'b00; seen = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1 reset state", hit, 1'b0);

    // table walk: R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      bit_vld = VEC[i][2]; bit_in = VEC[i][1];
      #1;
      check($sformatf("R2/R3/R4/R5/R6 table entry %0d", i), hit, VEC[i][0]);
    end

    // R1: reset interrupts a partial run
    do_reset();
    drive(1'b1, 1'b1, "R1 pre");
    drive(1'b1, 1'b1, "R1 pre");
    do_reset();
    drive(1'b1, 1'b1, "R1 first bit after reset");
    drive(1'b1, 1'b1, "R1 second bit after reset");
    drive(1'b1, 1'b1, "R2 third bit after reset");

    // R4: long constant runs
    do_reset();
    for (int i = 0; i < 60; i++) drive(1'b1, 1'b1, "R4 long ones");
    for (int i = 0; i < 60; i++) drive(1'b1, 1'b0, "R4 long zeros");

    // R5: alternating
    for (int i = 0; i < 80; i++) drive(1'b1, logic'(i[0]), "R5 alternating");

    // R6: gaps inside a run, bit_in toggling while invalid
    drive(1'b1, 1'b0, "R6 gap");
    for (int i = 0; i < 5; i++) drive(1'b0, 1'b1, "R6 invalid ignored");
    drive(1'b1, 1'b0, "R6 gap");
    for (int i = 0; i < 5; i++) drive(1'b0, 1'b1, "R6 invalid ignored");
    drive(1'b1, 1'b0, "R3 completes across gaps");

    // random stream: R2 R3 R4 R5 R6 R7
    do_reset();
    for (int i = 0; i < 5000; i++)
      drive(($urandom_range(3) != 0), logic'($urandom_range(1)), "R2/R3/R7 random");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule